// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block sits between a CAN receiver and its receive storage and decides, frame by frame, whether an already-assembled identifier word should be kept. It holds four filter slots. Each slot has a 32-bit compare mask, a 32-bit reference identifier and an enable bit. A slot matches when the bits selected by its mask agree between the incoming word and the reference. The frame is kept when any enabled slot matches. When every slot is disabled, all frames are kept.

The receiver presents the identifier word with a one-cycle valid strobe. The block then holds a busy flag for one evaluation cycle. In the following cycle it gives a one-cycle accept or reject pulse, together with the lowest-numbered matching slot.

Software programs the slots through a simple write port. A slot's mask and reference can only be rewritten while that slot is disabled and no evaluation is in progress. Writes made at any other time are dropped silently. The enable register can be written at any time.

The incoming word normally carries the 11-bit base identifier in bits 31:21, the substitute-remote bit in bit 20, the extension flag in bit 19, the 18-bit extension in bits 18:1 and the remote flag in bit 0. The compare is purely bitwise, so the filter does not depend on this layout.

Top module: `id_accept_bank`

## Requirements
- R1: After reset, all enables, masks and reference identifiers are zero, and `busy`, `acceptPulse`, `rejectPulse`, `slotHit` and `hitIdx` are low. The first frame after reset is accepted.
- R2: Slot k matches a frame when `(frameId & mask[k]) == (ref[k] & mask[k])`. Bits that are clear in the mask are don't-care.
- R3: When at least one slot is enabled, a frame is accepted if some enabled slot matches and rejected otherwise. A disabled slot never causes acceptance.
- R4: When no slot is enabled, every frame is accepted with `slotHit` = 0 and `hitIdx` = 0. `hitIdx` is 0 whenever `slotHit` is 0.
- R5: When several enabled slots match, `hitIdx` reports the lowest-numbered one and `slotHit` is 1. `slotHit` is only ever high together with `acceptPulse`.
- R6: A `frameValid` strobe sampled at clock edge N makes `busy` high between edges N and N+1. The single-cycle result pulse is then high between edges N+1 and N+2. No pulse appears without a preceding busy cycle.
- R7: A write to address 0 loads the slot enables from data bits 3:0. Bit 0 enables slot 0, and bit k enables slot k.
- R8: Address 8+2k writes the mask of slot k and address 9+2k writes its reference identifier. All other addresses have no effect.
- R9: A mask or reference write to an enabled slot is ignored.
- R10: A mask or reference write in a cycle where `busy` is high is ignored.
- R11: `acceptPulse` and `rejectPulse` are never high together. Each valid strobe produces exactly one of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | One-cycle strobe: `frameId` holds a new identifier word |
| frameId | input | 32 | Packed received identifier word |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address (0 enables, 8+2k mask k, 9+2k reference k) |
| regWrData | input | 32 | Register write data |
| busy | output | 1 | High during the evaluation cycle |
| acceptPulse | output | 1 | One-cycle pulse: frame kept |
| rejectPulse | output | 1 | One-cycle pulse: frame dropped |
| slotHit | output | 1 | Acceptance came from a matching enabled slot |
| hitIdx | output | 2 | Lowest-numbered matching enabled slot |

## Verification
The hardest case to reach from the ports is a slot write that lands exactly in the busy cycle. The write is dropped, and that can only be seen frames later. The bench sends a frame, drives a reference write to a disabled slot in the very next cycle, then enables that slot and shows that a frame carrying the old reference still matches. Random frames are mostly built from a chosen slot's reference, with the don't-care bits scrambled. This makes multi-slot overlaps and priority resolution occur often, rather than only as rare accidental matches.

// File: rtl/ida_pkg.sv
`timescale 1ns/1ps
package ida_pkg;
  localparam int NSLOT   = 4;
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam int ADDR_W  = SLOT_W + 2;

  // strobes from control to datapath
  typedef struct packed {
    logic             capture;
    logic             evaluate;
    logic             wrEnables;
    logic [NSLOT-1:0] wrMask;
    logic [NSLOT-1:0] wrIdent;
  } ida_strobe_t;
endpackage

// File: rtl/ida_ctrl.sv
`timescale 1ns/1ps
module ida_ctrl
  import ida_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frameValid,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [NSLOT-1:0]      enables,
  output ida_strobe_t           stb,
  output logic                  busy
);
  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= frameValid;
  end

  assign busy = pending;

  logic inSlotSpace;
  assign inSlotSpace = regWrEn && regAddr[ADDR_W-1];

  always_comb begin
    stb           = '0;
    stb.capture   = frameValid;
    stb.evaluate  = pending;
    stb.wrEnables = regWrEn && (regAddr == '0);
  end

  // per-slot write gating: slot must be disabled and no compare in flight
  logic [NSLOT-1:0] slotSel;
  genvar k;
  generate
    for (k = 0; k < NSLOT; k++) begin : g_sel
      assign slotSel[k] = inSlotSpace && (regAddr[SLOT_W:1] == SLOT_W'(k))
                          && !enables[k] && !pending;
    end
  endgenerate

  logic [NSLOT-1:0] maskSel, identSel;
  assign maskSel  = regAddr[0] ? '0 : slotSel;
  assign identSel = regAddr[0] ? slotSel : '0;

  // merge into struct outside always_comb to keep drivers single
  ida_strobe_t stbOut;
  always_comb begin
    stbOut         = stb;
    stbOut.wrMask  = maskSel;
    stbOut.wrIdent = identSel;
  end
endmodule

// File: rtl/ida_datapath.sv
`timescale 1ns/1ps
module ida_datapath
  import ida_pkg::*;
#(
  parameter int IDW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ida_strobe_t       stb,
  input  logic [IDW-1:0]    regWrData,
  input  logic [IDW-1:0]    frameId,
  output logic [NSLOT-1:0]  enables,
  output logic              acceptQ,
  output logic              rejectQ,
  output logic              hitQ,
  output logic [SLOT_W-1:0] idxQ
);
  logic [IDW-1:0]   capId;
  logic [NSLOT-1:0] enR;
  logic [NSLOT-1:0] hitVec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capId <= '0;
      enR   <= '0;
    end else begin
      if (stb.capture)   capId <= frameId;
      if (stb.wrEnables) enR   <= regWrData[NSLOT-1:0];
    end
  end

  assign enables = enR;

  genvar k;
  generate
    for (k = 0; k < NSLOT; k++) begin : g_slot
      logic [IDW-1:0] maskR, identR;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          maskR  <= '0;
          identR <= '0;
        end else begin
          if (stb.wrMask[k])  maskR  <= regWrData;
          if (stb.wrIdent[k]) identR <= regWrData;
        end
      end
      assign hitVec[k] = enR[k] && ((capId & maskR) == (identR & maskR));
    end
  endgenerate

  logic [SLOT_W-1:0] firstIdx;
  always_comb begin
    firstIdx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (hitVec[i]) firstIdx = SLOT_W'(i);
    end
  end

  logic keep;
  assign keep = (enR == '0) || (hitVec != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !stb.evaluate) begin
      acceptQ <= 1'b0;
      rejectQ <= 1'b0;
      hitQ    <= 1'b0;
      idxQ    <= '0;
    end else begin
      acceptQ <= keep;
      rejectQ <= !keep;
      hitQ    <= (hitVec != '0);
      idxQ    <= firstIdx;
    end
  end
endmodule

// File: rtl/id_accept_bank.sv
`timescale 1ns/1ps
module id_accept_bank
  import ida_pkg::*;
#(
  parameter int IDW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameValid,
  input  logic [IDW-1:0]    frameId,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [IDW-1:0]    regWrData,
  output logic              busy,
  output logic              acceptPulse,
  output logic              rejectPulse,
  output logic              slotHit,
  output logic [SLOT_W-1:0] hitIdx
);
  ida_strobe_t      stb;
  logic [NSLOT-1:0] enables;

  ida_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frameValid (frameValid),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .enables    (enables),
    .stb        (),
    .busy       (busy)
  );

  assign stb = i_ctrl.stbOut;

  ida_datapath #(.IDW(IDW)) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .regWrData (regWrData),
    .frameId   (frameId),
    .enables   (enables),
    .acceptQ   (acceptPulse),
    .rejectQ   (rejectPulse),
    .hitQ      (slotHit),
    .idxQ      (hitIdx)
  );
endmodule

// File: rtl/ida_checker.sv
`timescale 1ns/1ps
module ida_checker
  import ida_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frameValid,
  input logic              busy,
  input logic              acceptPulse,
  input logic              rejectPulse,
  input logic              slotHit,
  input logic [SLOT_W-1:0] hitIdx
);
  a_r6_busy_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frameValid |=> busy);

  a_r6_result_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (acceptPulse || rejectPulse));

  a_r6_no_orphan_result: assert property (@(posedge clk) disable iff (!rst_n)
    (acceptPulse || rejectPulse) |-> $past(busy));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(acceptPulse && rejectPulse));

  a_r5_hit_implies_accept: assert property (@(posedge clk) disable iff (!rst_n)
    slotHit |-> acceptPulse);

  a_r4_idx_zero_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !slotHit |-> (hitIdx == '0));
endmodule

bind id_accept_bank ida_checker i_ida_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .frameValid  (frameValid),
  .busy        (busy),
  .acceptPulse (acceptPulse),
  .rejectPulse (rejectPulse),
  .slotHit     (slotHit),
  .hitIdx      (hitIdx)
);

// File: tb/test_id_accept_bank.sv
`timescale 1ns/1ps
module test_id_accept_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frameValid = 1'b0;
  logic [31:0] frameId = '0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        busy, acceptPulse, rejectPulse, slotHit;
  logic [1:0]  hitIdx;

  always #2.5 clk = ~clk;

  id_accept_bank i_id_accept_bank (
    .clk(clk), .rst_n(rst_n), .frameValid(frameValid), .frameId(frameId),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .busy(busy), .acceptPulse(acceptPulse), .rejectPulse(rejectPulse),
    .slotHit(slotHit), .hitIdx(hitIdx)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [31:0] mMask [4];
  logic [31:0] mRef  [4];
  logic [3:0]  mEn;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  // expected {accept, hit, idx}
  function automatic logic [3:0] model(logic [31:0] id);
    logic hit = 1'b0;
    logic [1:0] idx = 2'd0;
    for (int k = 3; k >= 0; k--) begin
      if (mEn[k] && ((id & mMask[k]) == (mRef[k] & mMask[k]))) begin
        hit = 1'b1;
        idx = 2'(k);
      end
    end
    return {(mEn == 4'd0) || hit, hit, idx};
  endfunction

  task automatic writeReg(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 4'd0) mEn = d[3:0];
    else if (a[3]) begin
      int k = int'(a[2:1]);
      if (!mEn[k]) begin
        if (a[0]) mRef[k] = d; else mMask[k] = d;
      end
    end
  endtask

  // sends a frame; optionally issues a slot write during the busy cycle
  task automatic sendFrame(string req, logic [31:0] id, bit wrInBusy = 0,
                           logic [3:0] wa = 0, logic [31:0] wd = 0);
    logic [3:0] e = model(id);
    @(negedge clk);
    frameValid = 1'b1; frameId = id;
    @(negedge clk);
    frameValid = 1'b0;
    chk({req, " busy"}, 32'(busy), 32'd1);
    if (wrInBusy) begin regWrEn = 1'b1; regAddr = wa; regWrData = wd; end
    @(negedge clk);
    regWrEn = 1'b0;
    chk({req, " accept"}, 32'(acceptPulse), 32'(e[3]));
    chk({req, " reject"}, 32'(rejectPulse), 32'(!e[3]));
    chk({req, " hit"},    32'(slotHit),     32'(e[2]));
    chk({req, " idx"},    32'(hitIdx),      32'(e[1:0]));
    chk({req, " busy clear"}, 32'(busy), 32'd0);
    @(negedge clk);
    chk({req, " pulse width"}, 32'(acceptPulse | rejectPulse), 32'd0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) begin mMask[k] = '0; mRef[k] = '0; end
    mEn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 accept", 32'(acceptPulse), 0);
    chk("R1 reject", 32'(rejectPulse), 0);
    chk("R1 hit", 32'(slotHit), 0);
    sendFrame("R1 accept after reset", 32'hDEAD_BEEF);

    // R8 addressing and R4 all disabled
    writeReg(4'd8,  32'hFFE0_0000); writeReg(4'd9,  32'h1230_0000);
    writeReg(4'd10, 32'hFFE0_0000); writeReg(4'd11, 32'h4560_0000);
    writeReg(4'd12, 32'h0000_00FF); writeReg(4'd13, 32'h0000_0042);
    writeReg(4'd14, 32'h0000_0000); writeReg(4'd15, 32'h0000_0000);
    writeReg(4'd3,  32'hFFFF_FFFF);  // R8 unmapped address, no effect
    sendFrame("R4 none enabled", 32'h0BAD_F00D);

    // R7 bit0 -> slot0
    writeReg(4'd0, 32'h1);
    sendFrame("R7 slot0 match", 32'h1231_2345);
    sendFrame("R3 slot0 miss reject", 32'h4561_2345);
    // R2 don't-care bits
    sendFrame("R2 masked bits ignored", 32'h123F_FFFF);
    writeReg(4'd0, 32'h8);
    sendFrame("R7 slot3 zero mask hits", 32'h5555_AAAA);

    // R5 priority
    writeReg(4'd0, 32'h0);
    writeReg(4'd14, 32'hFFE0_0000); writeReg(4'd15, 32'h1230_0000);
    writeReg(4'd0, 32'hA);
    sendFrame("R3 disabled slot0 not used", 32'h4560_0000);
    sendFrame("R5 only slot3 matches", 32'h1230_0001);
    writeReg(4'd0, 32'hF);
    sendFrame("R5 lowest of 0 and 3", 32'h1230_0001);

    // R9 writes to enabled slot ignored
    writeReg(4'd9, 32'h7770_0000);
    sendFrame("R9 old ref still matches", 32'h1230_0000);
    sendFrame("R9 new ref rejected", 32'h7770_0000);

    // R10 write during busy ignored
    writeReg(4'd0, 32'h1);
    sendFrame("R10 frame with busy write", 32'h1230_0000, 1, 4'd11, 32'h3330_0000);
    writeReg(4'd0, 32'h2);
    sendFrame("R10 slot1 ref unchanged", 32'h4560_0000);
    sendFrame("R10 busy write dropped", 32'h3330_0000);

    // random mix: R2 R3 R5 R11
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom_range(0, 9));
      if (op == 0) writeReg(4'd0, $urandom);
      else if (op <= 2) writeReg(4'(8 + $urandom_range(0, 7)),
                                 (op == 1) ? ($urandom | $urandom) : $urandom);
      else begin
        int k = int'($urandom_range(0, 3));
        logic [31:0] id = (op <= 7) ? ((mRef[k] & mMask[k]) | ($urandom & ~mMask[k]))
                                    : $urandom;
        sendFrame("R11 random", id);
      end
    end
    summary();
  end
endmodule